// File: doc/BRIEF.md
# Edge-Captured Interrupt Status Bank

This block collects up to eight event inputs for one group of sources, such as receive alarms or a test-pattern lock indication. A source is detected on its low-to-high transition. The transition sets a sticky status bit, and that bit stays set until a processor reads the status register. The read returns the captured value and clears the register in the same cycle.

A per-bit enable register chooses which captured events go further. An enabled event also sets a request bit, and the request bits are ORed into a single interrupt line toward a global interrupt controller. A disabled event is still recorded in the status register, so a processor can poll it. Only the request bit and the interrupt line are held back.

Which bit positions are implemented is set by a parameter mask. The unimplemented (reserved) positions read as zero and ignore both sources and writes. The processor side is a small register port with an address, a write strobe, a read strobe and 8-bit data in each direction. Read data is registered and appears one cycle after the read strobe.

Top module: `irq_latch_bank`

## Requirements
- R1: After reset the status, enable and request registers are zero, `irq` is low and `rd_data` is zero.
- R2: A status bit is set by a low-to-high transition of its source, seen on the clock edge where the source is first sampled high. A source held high does not set the bit again after it has been cleared.
- R3: A set status bit stays set until a read strobe at address 0 (status). That read returns the register's value from before the clear on `rd_data` one cycle after the strobe, and the register is zero afterwards.
- R4: When enable bit n is 1, a transition on source n sets status bit n and request bit n (read at address 2), and `irq` goes high on the same clock edge.
- R5: When enable bit n is 0, a transition on source n sets status bit n but leaves request bit n at 0 and does not raise `irq`.
- R6: With the default mask 0x5B, bit positions 2, 5 and 7 are reserved. In every register these positions read as 0, a source transition there sets nothing, and a write of 1 to them has no effect.
- R7: When a source transition arrives on the same edge as a clearing status read, the bit is set again after the clear, and the event is kept.
- R8: `irq` is the OR of the request bits. A clearing status read also clears every request bit, so `irq` falls unless a new enabled transition arrives on that same edge.
- R9: The enable register is written and read at address 1. Writes to address 0 (status) and address 2 (request) have no effect.
- R10: Reads at address 1 or address 2 do not clear the status or request registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_src | input | 8 | Event sources, synchronous to `clk` |
| addr | input | 2 | Register select: 0 status, 1 enable, 2 request |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; a status read clears status and request |
| rd_data | output | 8 | Registered read data, valid the cycle after `rd_en` |
| irq | output | 1 | Interrupt toward the global controller |

## Verification
The bench places a source transition on the same edge as a clearing status read. A design that ordered the clear after the set would lose that event, and the following status read would return zero. It holds sources high across a clear, which catches a design that latches on level and sets the bit again straight away. It also leaves a source enabled while polling another one, which shows a design whose request bits or `irq` come back without a new transition. Reads of the enable and request registers placed before a status read show whether they clear anything by mistake. Sources and writes aimed at the reserved positions show whether the mask is applied everywhere it should be.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

  typedef enum logic [1:0] {
    SEL_STATUS  = 2'd0,
    SEL_ENABLE  = 2'd1,
    SEL_REQUEST = 2'd2
  } reg_sel_e;

  // A low-to-high transition between the previous and current sample
  function automatic logic rise_of(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction

  // The clear acts first and the set acts last, so a set on the clearing edge is kept
  function automatic logic sticky_next(input logic cur, input logic clr, input logic set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int          W    = 8,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  output logic [W-1:0] rise
);
  import irq_bank_pkg::*;

  logic [W-1:0] src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_live
      assign rise[i] = rise_of(src[i], src_q[i]);
    end else begin : g_rsvd
      assign rise[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_sticky_bit.sv
module irq_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set,
  output logic q
);
  import irq_bank_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= sticky_next(q, clr, set);
  end
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port #(
  parameter int           W      = 8,
  parameter int           ADDR_W = 2,
  parameter logic [W-1:0] MASK   = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [W-1:0]      wr_data,
  input  logic              rd_en,
  input  logic [W-1:0]      status,
  input  logic [W-1:0]      req,
  output logic [W-1:0]      enable,
  output logic [W-1:0]      rd_data,
  output logic              status_clr
);
  import irq_bank_pkg::*;

  logic hit_status, hit_enable, hit_request;
  logic [W-1:0] rd_mux;

  assign hit_status  = (addr == ADDR_W'(SEL_STATUS));
  assign hit_enable  = (addr == ADDR_W'(SEL_ENABLE));
  assign hit_request = (addr == ADDR_W'(SEL_REQUEST));

  assign status_clr = rd_en & hit_status;

  always_comb begin
    rd_mux = '0;
    if (hit_status)  rd_mux = status;
    if (hit_enable)  rd_mux = enable;
    if (hit_request) rd_mux = req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable  <= '0;
      rd_data <= '0;
    end else begin
      if (wr_en && hit_enable) enable <= wr_data & MASK;
      if (rd_en) rd_data <= rd_mux & MASK;
    end
  end
endmodule

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
  parameter int           W      = 8,
  parameter int           ADDR_W = 2,
  parameter logic [W-1:0] MASK   = 8'h5B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      evt_src,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [W-1:0]      wr_data,
  input  logic              rd_en,
  output logic [W-1:0]      rd_data,
  output logic              irq
);
  logic [W-1:0] rise_w;
  logic [W-1:0] status_q;
  logic [W-1:0] req_q;
  logic [W-1:0] enable_q;
  logic         clr_w;

  irq_edge_det #(.W(W), .MASK(MASK)) u_edge (
    .clk(clk), .rst_n(rst_n), .src(evt_src), .rise(rise_w)
  );

  irq_reg_port #(.W(W), .ADDR_W(ADDR_W), .MASK(MASK)) u_port (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .status(status_q), .req(req_q), .enable(enable_q),
    .rd_data(rd_data), .status_clr(clr_w)
  );

  for (genvar i = 0; i < W; i++) begin : g_bank
    if (MASK[i]) begin : g_live
      irq_sticky_bit u_stat (
        .clk(clk), .rst_n(rst_n), .clr(clr_w), .set(rise_w[i]), .q(status_q[i])
      );
      irq_sticky_bit u_req (
        .clk(clk), .rst_n(rst_n), .clr(clr_w),
        .set(rise_w[i] & enable_q[i]), .q(req_q[i])
      );
    end else begin : g_rsvd
      assign status_q[i] = 1'b0;
      assign req_q[i]    = 1'b0;
    end
  end

  assign irq = |req_q;
endmodule

// File: rtl/irq_latch_bank_chk.sv
module irq_latch_bank_chk #(
  parameter int           W    = 8,
  parameter logic [W-1:0] MASK = 8'h5B
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] rise,
  input logic [W-1:0] status,
  input logic [W-1:0] req,
  input logic [W-1:0] enable,
  input logic         clr,
  input logic         irq
);
  // R2
  status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((status & $past(rise)) == $past(rise)));

  // R3
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((status & $past(status)) == $past(status)));

  // R4
  req_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise & enable) != '0) |=> irq);

  // R5
  req_within_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((req & ~status) == '0));

  // R6
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((status | req | enable) & ~MASK) == '0));

  // R8
  req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((req & ~$past(rise & enable)) == '0));
endmodule

bind irq_latch_bank irq_latch_bank_chk #(.W(W), .MASK(MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .rise(rise_w), .status(status_q), .req(req_q),
  .enable(enable_q), .clr(clr_w), .irq(irq)
);

// File: tb/irq_latch_bank_bench.sv
module irq_latch_bank_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt_src = '0;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  irq_latch_bank u_irq_latch_bank (
    .clk(clk), .rst_n(rst_n), .evt_src(evt_src), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
  );

  // Monitor: read data is registered on the edge that samples rd_en
  always @(posedge clk) begin
    if (rst_n && rd_en) begin
      #1;
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL %s: unexpected read data %02h, expected none queued", "R3", rd_data);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if (rd_data !== e) begin
          n_bad++;
          $display("FAIL %s: rd_data %02h expected %02h", t, rd_data, e);
        end
      end
    end
  end

  task automatic do_read(input logic [1:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // A read with a source change that lands on the same edge
  task automatic do_read_src(input logic [1:0] a, input logic [7:0] s,
                             input logic [7:0] e, input string t);
    @(negedge clk);
    addr = a; rd_en = 1'b1; evt_src = s;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_src(input logic [7:0] s);
    @(negedge clk);
    evt_src = s;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    n_cmp++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s: irq %0b expected %0b", t, irq, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    n_cmp++;
    if (irq !== 1'b0 || rd_data !== 8'h00) begin
      n_bad++;
      $display("FAIL R1: irq/rd_data %0b/%02h expected 0/00", irq, rd_data);
    end
    rst_n = 1'b1;
    do_read(2'd0, 8'h00, "R1");
    do_read(2'd1, 8'h00, "R1");
    do_read(2'd2, 8'h00, "R1");
    chk_irq(1'b0, "R1");

    // R9 and R6: enable write/read with reserved positions dropped
    do_write(2'd1, 8'hFF);
    do_read(2'd1, 8'h5B, "R9");
    do_write(2'd1, 8'h03);
    do_read(2'd1, 8'h03, "R9");

    // R4: enabled source 0 plus disabled source 3
    set_src(8'h09);
    chk_irq(1'b1, "R4");
    do_read(2'd2, 8'h01, "R4");
    do_read(2'd1, 8'h03, "R10");
    do_read(2'd0, 8'h09, "R10");
    // R2: sources still high; no new set after the clear
    do_read(2'd0, 8'h00, "R2");
    do_read(2'd2, 8'h00, "R8");
    chk_irq(1'b0, "R8");

    // R5: disabled source 4
    set_src(8'h00);
    set_src(8'h10);
    chk_irq(1'b0, "R5");
    do_read(2'd2, 8'h00, "R5");
    do_read(2'd0, 8'h10, "R5");

    // R6: reserved sources 2, 5, 7 set nothing
    set_src(8'h00);
    set_src(8'hA4);
    chk_irq(1'b0, "R6");
    do_read(2'd0, 8'h00, "R6");
    // R9: writes to status and request are ignored
    do_write(2'd0, 8'hFF);
    do_write(2'd2, 8'hFF);
    do_read(2'd0, 8'h00, "R9");
    do_read(2'd2, 8'h00, "R9");

    // R7: transition on the clearing edge is kept
    set_src(8'h00);
    do_write(2'd1, 8'h01);
    set_src(8'h02);
    do_read_src(2'd0, 8'h03, 8'h02, "R7");
    chk_irq(1'b1, "R7");
    do_read(2'd0, 8'h01, "R7");
    chk_irq(1'b0, "R8");

    repeat (3) @(negedge clk);
    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R3: %0d reads unanswered, expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule